// File: doc/BRIEF.md
# I2C Target Memory Read Engine

This block is the serial front end of a byte-addressed memory that is read over a two-wire I2C bus. It watches SCL and SDA, both oversampled by the system clock, and finds START, STOP and repeated START conditions. It answers to one fixed 7-bit target address. It takes a two-byte word address and sends data bytes back from a memory read port. An auto-incrementing counter keeps the address between transfers.

Four read patterns are supported:
- **Current-address read:** the byte comes from wherever the counter stands.
- **Random read:** a write-direction phase carries the word address, then a repeated START turns the transfer around to reading.
- **Sequential read:** the master acknowledges each byte to request the next one.
- **Set-address:** the write phase is closed with STOP, which only loads the counter and returns no data.

The master's acknowledge bit on the ninth clock decides whether reading continues. A NACK ends output at once. After a STOP, or after a NACK, the block stays silent until it sees a new START.

Top module: `i2c_rd_target`

## Requirements
- R1: After reset, and after any STOP, `sda_pull_o` is 0. Clock pulses and data on the bus are ignored until a START is detected, so a full byte clocked without a START gets no acknowledge.
- R2: The first byte after a START is the target address (bits 7..1) and the direction bit (bit 0: 0 = write, 1 = read). On a match with `TARGET_ADDR` (default 7'h5B), the block pulls SDA low for the whole ninth clock. On a mismatch it never pulls SDA before the next START.
- R3: In the write direction, two word address bytes follow, high byte first, and each one is acknowledged. Only the low `ADDR_W` (9) bits of the 16-bit value are kept, so bit 0 of the high byte becomes address bit 8.
- R4: A STOP that follows the acknowledged word address loads that address into the counter (visible on `mem_addr_o`) and sends no data. The next current-address read starts there.
- R5: A repeated START after the word address, followed by the target address with the read bit, is acknowledged. It is then followed by the byte stored at that word address.
- R6: A START followed by the target address with the read bit returns the byte at the current counter value.
- R7: Each byte sent advances the counter by one. A master ACK (SDA low) on the ninth clock causes the byte at the next address to be sent.
- R8: The counter wraps from 0x1FF to 0x000 during sequential reads, and output continues across the wrap.
- R9: A master NACK (SDA high) on the ninth clock ends the read. The block releases SDA and does not pull it on any later clock until a new START.
- R10: Data bits go out MSB first. `sda_pull_o` changes only while SCL is low, and incoming bits are taken on the SCL rising edge.
- R11: The SDA output is open-drain. `sda_pull_o` = 1 pulls the line low (acknowledge or data 0), and `sda_pull_o` = 0 releases it (data 1 or idle).
- R12: `mem_addr_o` always shows the counter, which is 0 after reset. A transmitted byte is captured from `mem_data_i` on the SCL falling edge that begins it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| mem_addr_o | output | ADDR_W (9) | Memory read address (the address counter) |
| mem_data_i | input | 8 | Memory read data for `mem_addr_o` |

## Verification
A wrong sequencing state shows up on SDA within one bus bit. It appears as a missing or extra pull on the ninth clock, or as a data bit driven while the master expects a released line. A wrong counter value appears on `mem_addr_o` at once and in the next byte returned. The full 513-byte sequential sweep therefore checks every address and the wrap against the memory model's arithmetic pattern.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_XTRA
    } ph_e;

endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
    parameter int            WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [1:0] ff_q;
        logic [1:0] ff_d;

        always_comb begin
            ff_d = {ff_q[0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= {2{RST_VAL[g]}};
            else        ff_q <= ff_d;
        end

        assign sync_o[g] = ff_q[1];
    end

endmodule

// File: rtl/i2c_rd_events.sv
module i2c_rd_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic scl_q, sda_q;
    logic scl_d, sda_d;

    always_comb begin
        scl_d = scl_i;
        sda_d = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    // SDA moving while SCL stays high marks a bus condition
    assign start_o = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
    assign rise_o  = scl_i & ~scl_q;
    assign fall_o  = ~scl_i & scl_q;

endmodule

// File: rtl/i2c_rd_addr_ctr.sv
module i2c_rd_addr_ctr #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)     cnt_d = load_val_i;
        else if (inc_i) cnt_d = cnt_q + 1'b1;   // natural wrap at 2**ADDR_W
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign addr_o = cnt_q;

    // R7 / R8: an increment moves the counter by exactly one, modulo the space
    assert_step_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc_i) && !$past(load_i)) |-> (cnt_q == ADDR_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target
    import i2c_rd_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h5B,
    parameter int         ADDR_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              rw;
        logic              pull;
        logic [7:0]        ahi;
        logic [ADDR_W-1:0] wa;
        logic              pend;
        logic              mack;
    } regs_t;

    regs_t q, d;

    logic scl_s, sda_s;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic ctr_load, ctr_inc;

    i2c_rd_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  ({scl_s, sda_s})
    );

    i2c_rd_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_s),
        .sda_i   (sda_s),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    i2c_rd_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (q.wa),
        .inc_i      (ctr_inc),
        .addr_o     (mem_addr_o)
    );

    always_comb begin
        d        = q;
        ctr_load = 1'b0;
        ctr_inc  = 1'b0;

        if (ev_start) begin
            // a completed word address is committed by START or STOP alike
            ctr_load = q.pend;
            d.pend   = 1'b0;
            d.st     = ST_RX;
            d.ph     = PH_DEV;
            d.cnt    = '0;
            d.pull   = 1'b0;
        end else if (ev_stop) begin
            ctr_load = q.pend;
            d.pend   = 1'b0;
            d.st     = ST_IDLE;
            d.pull   = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.pull = 1'b0;
                end

                ST_RX: begin
                    if (ev_rise && q.cnt != BITS_PER_BYTE) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (ev_fall && q.cnt == BITS_PER_BYTE) begin
                        d.cnt = '0;
                        unique case (q.ph)
                            PH_DEV: begin
                                if (q.sh[7:1] == TARGET_ADDR) begin
                                    d.rw   = q.sh[0];
                                    d.st   = ST_ACK;
                                    d.pull = 1'b1;
                                end else begin
                                    d.st   = ST_IDLE;
                                end
                            end
                            PH_AHI: begin
                                d.ahi  = q.sh;
                                d.st   = ST_ACK;
                                d.pull = 1'b1;
                            end
                            PH_ALO: begin
                                d.wa   = ADDR_W'({q.ahi, q.sh});
                                d.st   = ST_ACK;
                                d.pull = 1'b1;
                            end
                            default: begin
                                // bytes past the word address are not taken
                                d.st   = ST_IDLE;
                            end
                        endcase
                    end
                end

                ST_ACK: begin
                    if (ev_fall) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        unique case (q.ph)
                            PH_DEV: begin
                                if (q.rw) begin
                                    d.st   = ST_TX;
                                    d.sh   = mem_data_i;
                                    d.pull = ~mem_data_i[7];
                                end else begin
                                    d.st   = ST_RX;
                                    d.ph   = PH_AHI;
                                end
                            end
                            PH_AHI: begin
                                d.st = ST_RX;
                                d.ph = PH_ALO;
                            end
                            PH_ALO: begin
                                d.st   = ST_RX;
                                d.ph   = PH_XTRA;
                                d.pend = 1'b1;
                            end
                            default: begin
                                d.st   = ST_IDLE;
                            end
                        endcase
                    end
                end

                ST_TX: begin
                    if (ev_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (ev_fall) begin
                        if (q.cnt == BITS_PER_BYTE) begin
                            d.st    = ST_MACK;
                            d.pull  = 1'b0;
                            ctr_inc = 1'b1;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.pull = ~q.sh[6];
                        end
                    end
                end

                ST_MACK: begin
                    if (ev_rise) begin
                        d.mack = ~sda_s;
                    end else if (ev_fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.st   = ST_TX;
                            d.sh   = mem_data_i;
                            d.pull = ~mem_data_i[7];
                        end else begin
                            d.st   = ST_IDLE;
                        end
                    end
                end

                default: begin
                    d.st   = ST_IDLE;
                    d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: PH_DEV, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;

    // R10: the SDA driver only moves after SCL was seen low
    assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pull != $past(q.pull)) |-> !$past(scl_s));

    // R1: the waiting state never holds the line
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_pull_o);

    // R9: the master owns SDA during its acknowledge slot
    assert_mack_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MACK) |-> !sda_pull_o);

    // R2: a target-address byte still being received is never answered
    assert_rx_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX) |-> !sda_pull_o);

endmodule

// File: tb/i2c_rd_target_tb.sv
`timescale 1ns/1ps
module i2c_rd_target_tb;

    localparam int Q      = 5;
    localparam int ADDR_W = 9;
    localparam logic [7:0] DEV_W = 8'hB6;   // 7'h5B, write
    localparam logic [7:0] DEV_R = 8'hB7;   // 7'h5B, read
    localparam logic [7:0] BAD_W = 8'hB4;   // 7'h5A

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_data;

    int tests = 0;
    int fails = 0;
    int r10_viol = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    function automatic logic [7:0] mem_f(input int a);
        return 8'((((a & 255) * 5) + (((a >> 8) & 1) * 99)) & 255);
    endfunction

    assign sda_line = m_sda & ~sda_pull;
    assign mem_data = mem_f(int'(mem_addr));

    i2c_rd_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .mem_addr_o (mem_addr),
        .mem_data_i (mem_data)
    );

    // R10 monitor: the driver must not change while SCL is high
    logic prev_pull = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_pull != prev_pull && m_scl) r10_viol++;
        prev_pull <= sda_pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b, output logic pull);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line;
        pull = sda_pull;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] v, output bit ack, output bit pulled);
        logic b, p;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b, p);
        ack = !b;
        pulled = p;
    endtask

    task automatic read_byte(output logic [7:0] v, input bit master_ack);
        logic b, p;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b, p);
            v[i] = b;
        end
        send_bit(master_ack ? 1'b0 : 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog R1..all act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        bit ack, pulled;
        logic [7:0] v;
        logic b, p;

        repeat (5) @(negedge clk);
        // R1 / R12: reset state
        chk(sda_pull == 1'b0, "R1 reset release", int'(sda_pull), 0);
        chk(mem_addr == '0, "R12 reset address", int'(mem_addr), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        m_scl = 1'b0; wq();

        // R1: matching byte clocked with no START is ignored
        write_byte(DEV_W, ack, pulled);
        chk(!ack, "R1 no START no ack", int'(ack), 0);
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();

        // R2: wrong target address
        bus_start();
        write_byte(BAD_W, ack, pulled);
        chk(!ack, "R2 mismatch no ack", int'(ack), 0);
        write_byte(8'h00, ack, pulled);
        chk(!ack, "R2 silent after mismatch", int'(ack), 0);
        bus_stop();

        // R3 / R4: set-address only, high byte 0x03 keeps bit 0 only -> 0x1A5
        bus_start();
        write_byte(DEV_W, ack, pulled);
        chk(ack, "R2 match ack", int'(ack), 1);
        chk(pulled, "R11 ack by pull", int'(pulled), 1);
        write_byte(8'h03, ack, pulled);
        chk(ack, "R3 high byte ack", int'(ack), 1);
        write_byte(8'hA5, ack, pulled);
        chk(ack, "R3 low byte ack", int'(ack), 1);
        bus_stop();
        wq();
        chk(mem_addr == 9'h1A5, "R4 set-address load", int'(mem_addr), 'h1A5);
        chk(sda_pull == 1'b0, "R4 no data after STOP", int'(sda_pull), 0);

        // R6: current-address read
        bus_start();
        write_byte(DEV_R, ack, pulled);
        chk(ack, "R6 read address ack", int'(ack), 1);
        read_byte(v, 1'b0);
        chk(v == mem_f('h1A5), "R6 current read data", int'(v), int'(mem_f('h1A5)));
        bus_stop();
        wq();
        chk(mem_addr == 9'h1A6, "R7 counter advance", int'(mem_addr), 'h1A6);

        // R5 / R7: random read at 0x010, four bytes
        bus_start();
        write_byte(DEV_W, ack, pulled);
        write_byte(8'h00, ack, pulled);
        write_byte(8'h10, ack, pulled);
        bus_start();
        write_byte(DEV_R, ack, pulled);
        chk(ack, "R5 repeated START read ack", int'(ack), 1);
        for (int i = 0; i < 4; i++) begin
            read_byte(v, i != 3);
            chk(v == mem_f('h10 + i), "R5_R7 random sequential data", int'(v), int'(mem_f('h10 + i)));
        end

        // R9: after NACK (no STOP yet) further clocks get no response
        for (int i = 0; i < 9; i++) begin
            recv_bit(b, p);
            chk(b == 1'b1 && p == 1'b0, "R9 silent after NACK", int'(p), 0);
        end
        bus_stop();

        // R8: wrap 0x1FE -> 0x001
        bus_start();
        write_byte(DEV_W, ack, pulled);
        write_byte(8'h01, ack, pulled);
        write_byte(8'hFE, ack, pulled);
        bus_start();
        write_byte(DEV_R, ack, pulled);
        for (int i = 0; i < 4; i++) begin
            read_byte(v, i != 3);
            chk(v == mem_f(('h1FE + i) % 512), "R8 wrap data", int'(v), int'(mem_f(('h1FE + i) % 512)));
        end
        bus_stop();

        // R7 / R8: exhaustive sweep of all 512 locations plus one past the wrap
        bus_start();
        write_byte(DEV_W, ack, pulled);
        write_byte(8'h00, ack, pulled);
        write_byte(8'h00, ack, pulled);
        bus_start();
        write_byte(DEV_R, ack, pulled);
        for (int i = 0; i < 513; i++) begin
            read_byte(v, i != 512);
            chk(v == mem_f(i % 512), "R7_R8 sweep data", int'(v), int'(mem_f(i % 512)));
        end
        bus_stop();
        wq();
        chk(mem_addr == 9'h001, "R8 counter after sweep", int'(mem_addr), 1);

        chk(r10_viol == 0, "R10 driver moved with SCL high", r10_viol, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule